// File: doc/BRIEF.md
# Sector Decoder Buffer Writer

This block takes in incoming disc sectors one at a time and places them in a 16 KB ring buffer made of bytes. Each sector arrives as a 4-byte header, offered on a valid/ready channel, followed by 2048 payload bytes on a second valid/ready byte channel. Two enable pins act as control bits. `dec_en` turns decoding on. `wr_en` requests that the sector also be stored in the buffer. The block does no error correction and has no drive interface.

When a header is accepted with decoding enabled, the four header bytes are latched into a header register and a one-cycle decoder interrupt strobe is raised. When storage is also requested, the block pointer and the write address each move forward by one raw-sector stride of 2352 bytes, modulo 16 KB. Only after that update does the block write the header and then the payload through a byte-wide RAM write port, starting at the updated block pointer. Addresses that pass the top of the buffer wrap to zero.

Back-pressure rules:
- The header channel is ready only while no sector is being stored. A header stays pending while `sec_valid` is held, and it is taken on the first idle cycle.
- The payload channel is ready only during the payload phase. A payload byte is consumed, and written, in exactly the cycles where `dat_valid` and `dat_ready` are both high.
- While a byte is not accepted, the producer must hold it.

Top module: `sector_buf_writer`

## Requirements
- R1: A header accepted while `dec_en` is 0 changes nothing. `hdr_q`, `blk_ptr` and `wr_addr` keep their values, `dec_irq` stays low and no RAM write takes place.
- R2: A header accepted while `dec_en` is 1 is visible on `hdr_q` in the next cycle. `dec_irq` is high for exactly that next cycle per accepted header.
- R3: With `dec_en` 1 and `wr_en` 0 at acceptance, the header and interrupt update as in R2. The pointers do not move, `busy` stays low and no RAM write takes place.
- R4: With both enables at 1 at acceptance, `blk_ptr` and `wr_addr` each increase by 2352 modulo 16384 in the next cycle. The new `blk_ptr` is the base address of the sector's stores.
- R5: In the four cycles right after acceptance, `ram_we` is high and header byte k (bits 8k+7:8k of `sec_hdr`) is written at base+k, for k = 0 to 3.
- R6: Payload byte i (counting from 0) is written at base+4+i, one byte per handshake cycle, and exactly 2048 payload bytes are written.
- R7: Every store address is (base+offset) modulo 16384, so a sector that runs past 0x3FFF continues at address 0.
- R8: `busy` is high from the cycle after acceptance through the cycle that writes the last payload byte. `sec_ready` equals not `busy`. `dat_ready` is high only in the payload phase. `ram_we` is low whenever `busy` is low.
- R9: After reset, `blk_ptr` is 0, `wr_addr` is 2352, `hdr_q` is 0, and `dec_irq` and `busy` are low.
- R10: The enables are sampled only at header acceptance. Changing them while a sector is being stored does not affect that sector's writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_en | input | 1 | Decoding enable |
| wr_en | input | 1 | Buffer store request |
| sec_valid | input | 1 | Sector header valid |
| sec_ready | output | 1 | Sector header ready (block idle) |
| sec_hdr | input | 32 | Header, byte k in bits 8k+7:8k |
| dat_valid | input | 1 | Payload byte valid |
| dat_ready | output | 1 | Payload byte ready |
| dat_byte | input | 8 | Payload byte |
| ram_we | output | 1 | Buffer write strobe |
| ram_addr | output | 14 | Buffer write address |
| ram_wdata | output | 8 | Buffer write data |
| blk_ptr | output | 14 | Block pointer |
| wr_addr | output | 14 | Write address register |
| hdr_q | output | 32 | Latched header |
| dec_irq | output | 1 | Decoder interrupt strobe |
| busy | output | 1 | Sector store in progress |

## Verification
The hardest case to reach is a sector that wraps in the middle of its stores. Because of the 2352-byte stride, the first base close enough to the top of the buffer comes only with the 27th stored sector, at base 14352. From there, exactly 20 bytes land at addresses 0 to 19.

The stimulus reaches that point by streaming sectors back to back:
- Headers are held valid during `busy`, so each one is taken on the first idle cycle.
- Decode-off and store-off sectors are mixed in to show that they do not move the pointers.
- Payload stalls are pseudo-random on alternate sectors.
- The enables are toggled during every store.

// File: rtl/sbw_pkg.sv
package sbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2
  } sbw_state_e;

  localparam int SBW_AW_DEF    = 14;
  localparam int SBW_HB_DEF    = 4;
  localparam int SBW_DB_DEF    = 2048;
  localparam int SBW_STEP_DEF  = 2352;
endpackage

// File: rtl/sbw_hdr.sv
module sbw_hdr #(
  parameter int HB = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [8*HB-1:0] hdr_in,
  output logic [8*HB-1:0] hdr_q,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hdr_q <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= load;
      if (load) hdr_q <= hdr_in;
    end
  end
endmodule

// File: rtl/sbw_ptr.sv
module sbw_ptr #(
  parameter int AW       = 14,
  parameter int STEP     = 2352,
  parameter int PTR_INIT = 0,
  parameter int WA_INIT  = 2352
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic [AW-1:0] blk_ptr,
  output logic [AW-1:0] wr_addr
);
  localparam logic [AW-1:0] STEP_V = AW'(STEP);

  logic [AW-1:0] regs [2];

  for (genvar g = 0; g < 2; g++) begin : g_reg
    localparam logic [AW-1:0] INIT_V = (g == 0) ? AW'(PTR_INIT) : AW'(WA_INIT);
    always_ff @(posedge clk) begin
      if (!rst_n)   regs[g] <= INIT_V;
      else if (adv) regs[g] <= regs[g] + STEP_V;
    end
  end

  assign blk_ptr = regs[0];
  assign wr_addr = regs[1];
endmodule

// File: rtl/sbw_seq.sv
module sbw_seq
  import sbw_pkg::*;
#(
  parameter int AW = 14,
  parameter int HB = 4,
  parameter int DB = 2048
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [8*HB-1:0] hdr,
  input  logic [AW-1:0]   base,
  input  logic            dat_valid,
  input  logic [7:0]      dat_byte,
  output logic            busy,
  output logic            idle,
  output logic            dat_ready,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [7:0]      ram_wdata
);
  localparam int TOTAL = HB + DB;
  localparam int CW    = $clog2(TOTAL + 1);
  localparam int HSW   = (HB > 1) ? $clog2(HB) : 1;

  sbw_state_e     st;
  logic [CW-1:0]  cnt;
  logic           last_hdr, last_dat;
  logic [HSW-1:0] hsel;
  logic [7:0]     hdr_byte;

  assign last_hdr = (cnt == CW'(HB - 1));
  assign last_dat = (cnt == CW'(TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          st  <= ST_HDR;
          cnt <= '0;
        end
        ST_HDR: begin
          cnt <= cnt + 1'b1;
          if (last_hdr) st <= ST_DATA;
        end
        ST_DATA: if (dat_valid) begin
          if (last_dat) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign hsel      = cnt[HSW-1:0];
  assign hdr_byte  = hdr[8*hsel +: 8];
  assign idle      = (st == ST_IDLE);
  assign busy      = !idle;
  assign dat_ready = (st == ST_DATA);
  assign ram_we    = (st == ST_HDR) || ((st == ST_DATA) && dat_valid);
  assign ram_addr  = base + AW'(cnt);
  assign ram_wdata = (st == ST_HDR) ? hdr_byte : dat_byte;

  // R5
  hdr_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HDR) |-> ram_we);

  // R6
  data_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && ram_we && !last_dat) |=> (ram_addr == $past(ram_addr) + 1'b1));

  // R6
  data_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DATA && !dat_valid) |=> $stable(ram_addr));
endmodule

// File: rtl/sector_buf_writer.sv
module sector_buf_writer
  import sbw_pkg::*;
#(
  parameter int AW       = SBW_AW_DEF,
  parameter int HB       = SBW_HB_DEF,
  parameter int DB       = SBW_DB_DEF,
  parameter int STEP     = SBW_STEP_DEF,
  parameter int PTR_INIT = 0,
  parameter int WA_INIT  = SBW_STEP_DEF
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dec_en,
  input  logic            wr_en,
  input  logic            sec_valid,
  output logic            sec_ready,
  input  logic [8*HB-1:0] sec_hdr,
  input  logic            dat_valid,
  output logic            dat_ready,
  input  logic [7:0]      dat_byte,
  output logic            ram_we,
  output logic [AW-1:0]   ram_addr,
  output logic [7:0]      ram_wdata,
  output logic [AW-1:0]   blk_ptr,
  output logic [AW-1:0]   wr_addr,
  output logic [8*HB-1:0] hdr_q,
  output logic            dec_irq,
  output logic            busy
);
  logic acc, load, adv, idle;

  assign acc       = sec_valid && idle;
  assign load      = acc && dec_en;
  assign adv       = load && wr_en;
  assign sec_ready = idle;

  sbw_hdr #(.HB(HB)) u_hdr (
    .clk(clk), .rst_n(rst_n), .load(load), .hdr_in(sec_hdr),
    .hdr_q(hdr_q), .irq(dec_irq)
  );

  sbw_ptr #(.AW(AW), .STEP(STEP), .PTR_INIT(PTR_INIT), .WA_INIT(WA_INIT)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(adv), .blk_ptr(blk_ptr), .wr_addr(wr_addr)
  );

  sbw_seq #(.AW(AW), .HB(HB), .DB(DB)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(adv), .hdr(hdr_q), .base(blk_ptr),
    .dat_valid(dat_valid), .dat_byte(dat_byte), .busy(busy), .idle(idle),
    .dat_ready(dat_ready), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  // R1
  dec_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_ready && !dec_en) |=> (!busy && !dec_irq && $stable(blk_ptr) && $stable(hdr_q)));

  // R2
  hdr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_ready && dec_en) |=> (dec_irq && hdr_q == $past(sec_hdr)));

  // R3
  no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_ready && dec_en && !wr_en) |=> (!busy && $stable(blk_ptr) && $stable(wr_addr)));

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_valid && sec_ready && dec_en && wr_en) |=>
      (busy && blk_ptr == $past(blk_ptr) + AW'(STEP) && wr_addr == $past(wr_addr) + AW'(STEP)));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!ram_we && !dat_ready));
endmodule

// File: tb/sim_sector_buf_writer.sv
`timescale 1ns/1ps
module sim_sector_buf_writer;
  localparam int BUF   = 16384;
  localparam int STEP  = 2352;
  localparam int NWR   = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dec_en = 1'b0, wr_en = 1'b0;
  logic        sec_valid = 1'b0;
  logic        sec_ready;
  logic [31:0] sec_hdr = '0;
  logic        dat_valid = 1'b0;
  logic        dat_ready;
  logic [7:0]  dat_byte = 8'h3C;
  logic        ram_we;
  logic [13:0] ram_addr;
  logic [7:0]  ram_wdata;
  logic [13:0] blk_ptr, wr_addr;
  logic [31:0] hdr_q;
  logic        dec_irq, busy;

  always #5 clk = ~clk;

  sector_buf_writer u0 (
    .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .wr_en(wr_en),
    .sec_valid(sec_valid), .sec_ready(sec_ready), .sec_hdr(sec_hdr),
    .dat_valid(dat_valid), .dat_ready(dat_ready), .dat_byte(dat_byte),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .blk_ptr(blk_ptr), .wr_addr(wr_addr), .hdr_q(hdr_q),
    .dec_irq(dec_irq), .busy(busy)
  );

  int checks = 0, fails = 0;
  int m_phase = 0, m_cnt = 0, m_base = 0;
  int m_ptr = 0, m_wa = STEP;
  logic [31:0] m_head = '0;
  bit m_irq = 0;
  int sidx = 0, writers = 0, wraps = 0, last_kind = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr_of(input int k);
    return {8'(k + 16), 8'(8'hA5 ^ 8'(k)), 8'(k * 7 + 1), 8'(k)};
  endfunction

  function automatic bit de_of(input int k);
    if (k == 0) return 0;
    if (k % 5 == 4 && k < 12) return 0;
    return 1;
  endfunction

  function automatic bit we_of(input int k);
    if (k == 1 || k % 5 == 2) return 0;
    return 1;
  endfunction

  task automatic step();
    bit e_we; int e_addr; int e_wd; string rq;
    #1;
    e_we   = (m_phase == 1) || (m_phase == 2 && dat_valid);
    e_addr = (m_base + m_cnt) % BUF;
    e_wd   = (m_phase == 1) ? int'((m_head >> (8 * m_cnt)) & 32'hFF) : int'(dat_byte);
    rq = (m_phase == 0) ? "R8" : "R10";
    chk(sec_ready == (m_phase == 0), "R8", "sec_ready", sec_ready, m_phase == 0);
    chk(dat_ready == (m_phase == 2), "R8", "dat_ready", dat_ready, m_phase == 2);
    chk(busy == (m_phase != 0), rq, "busy", busy, m_phase != 0);
    chk(ram_we == e_we, (m_phase == 1) ? "R5" : "R6", "ram_we", ram_we, e_we);
    if (e_we) begin
      chk(int'(ram_addr) == e_addr, (m_base + m_cnt >= BUF) ? "R7" : "R6", "ram_addr", ram_addr, e_addr);
      chk(int'(ram_wdata) == e_wd, (m_phase == 1) ? "R5" : "R6", "ram_wdata", ram_wdata, e_wd);
      if (m_base + m_cnt >= BUF) wraps++;
    end
    chk(int'(blk_ptr) == m_ptr, "R4", "blk_ptr", blk_ptr, m_ptr);
    chk(int'(wr_addr) == m_wa, "R4", "wr_addr", wr_addr, m_wa);
    chk(hdr_q == m_head, "R2", "hdr_q", hdr_q, m_head);
    chk(dec_irq == m_irq, "R2", "dec_irq", dec_irq, m_irq);
    // R1: decode-off sector left no trace one cycle later
    if (last_kind == 1) chk(!busy && !dec_irq, "R1", "busy|irq", {busy, dec_irq}, 0);
    // R3: store-off sector raised the strobe but started no store
    if (last_kind == 2) chk(!busy && dec_irq, "R3", "busy,irq", {busy, dec_irq}, 1);
    last_kind = 0;
    // model advance for the coming edge
    m_irq = 0;
    case (m_phase)
      0: if (sec_valid) begin
        if (dec_en) begin
          m_head = sec_hdr;
          m_irq = 1;
          if (wr_en) begin
            m_ptr = (m_ptr + STEP) % BUF;
            m_wa  = (m_wa + STEP) % BUF;
            m_base = m_ptr;
            m_phase = 1;
            m_cnt = 0;
            writers++;
          end else last_kind = 2;
        end else last_kind = 1;
        sidx++;
      end
      1: begin
        m_cnt++;
        if (m_cnt == 4) m_phase = 2;
      end
      default: if (dat_valid) begin
        m_cnt++;
        dat_byte = lfsr[15:8] ^ 8'(m_cnt);
        if (m_cnt == 2052) begin
          m_phase = 0;
          m_cnt = 0;
        end
      end
    endcase
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R9: reset values
    chk(blk_ptr == 14'd0, "R9", "blk_ptr", blk_ptr, 0);
    chk(wr_addr == 14'd2352, "R9", "wr_addr", wr_addr, 2352);
    chk(hdr_q == 32'd0 && !dec_irq && !busy, "R9", "hdr/irq/busy", {hdr_q[7:0], dec_irq, busy}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    while (!(writers == NWR && m_phase == 0)) begin
      if (m_phase == 0) begin
        dec_en = de_of(sidx);
        wr_en  = we_of(sidx);
      end else begin
        dec_en = lfsr[3];  // R10: enables wander during a store
        wr_en  = lfsr[4];
      end
      sec_valid = (writers < NWR);
      sec_hdr   = hdr_of(sidx);
      dat_valid = (sidx % 2 == 0) ? 1'b1 : (lfsr[0] | lfsr[1]);
      step();
    end
    sec_valid = 1'b0;
    dat_valid = 1'b1;
    step();
    // R7: the 27th stored sector (base 14352) wraps its last 20 bytes
    chk(wraps == 20, "R7", "wrapped writes", wraps, 20);
    // R4: final pointer values after 28 stored sectors
    chk(int'(blk_ptr) == (NWR * STEP) % BUF, "R4", "final blk_ptr", blk_ptr, (NWR * STEP) % BUF);
    chk(int'(wr_addr) == (STEP + NWR * STEP) % BUF, "R4", "final wr_addr", wr_addr, (STEP + NWR * STEP) % BUF);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", writers, NWR);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule